// File: doc/BRIEF.md
# Counter-Polling Bus Arbiter

This block decides which of NUM_DEV devices may drive a shared bus. Each device raises its own request bit. The OR of these bits acts as the common request line. When that line is high and the bus is free, the arbiter starts a poll counter. It drives the count onto a shared poll bus for one clock per value. Each device has an ID comparator. The first requesting device whose ID equals the current poll value takes the bus. Busy then goes high, that device's grant bit is set, and the counter stops.

The owner keeps the bus for as long as it holds its request. When it drops the request, busy falls and the arbiter returns to idle. The next scan can begin at one of two places. In fixed mode it starts at a start value written by software, for example 0 or the middle of the ID range. In rotating mode it starts at the last winner plus one, which gives round-robin fairness. A scan that goes through all NUM_DEV IDs without a match returns to idle. Data, address and transfer timing on the bus are not handled here.

Top module: `pollArbiter`

## Requirements
- R1: During and after reset, until a request arrives, busy is 0, grantVec is 0 and pollValid is 0.
- R2: Polling starts only from idle, when at least one request bit is high. In the clock after such a request is seen, pollValid is 1. With no request, pollValid stays 0.
- R3: While polling without a match, pollVal steps by one each clock and wraps from NUM_DEV-1 to 0.
- R4: If the device whose ID equals pollVal is requesting, then one clock later busy is 1, ownerId equals that ID and grantVec equals 1 shifted left by that ID.
- R5: At most one grantVec bit is ever set, and grantVec is non-zero exactly when busy is 1.
- R6: While busy, pollVal holds its value, pollValid is 0, and requests from other devices do not change the grant.
- R7: When the owner's request bit goes low, busy and grantVec are 0 one clock later.
- R8: With cfgRotate = 0, every scan begins with pollVal equal to cfgStart, which must be below NUM_DEV.
- R9: With cfgRotate = 1, every scan begins at the last winner plus one, modulo NUM_DEV. After reset the last winner counts as NUM_DEV-1, so the first scan begins at 0.
- R10: A scan of NUM_DEV polls that finds no requesting device returns to idle. pollValid is then high for exactly NUM_DEV clocks.
- R11: In rotating mode, if every device keeps re-requesting, grants go to consecutive IDs modulo NUM_DEV, and every device is granted within NUM_DEV grants.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqVec | input | NUM_DEV | Request bit per device; bit i belongs to device ID i |
| cfgStart | input | IDW | Scan start value used in fixed mode |
| cfgRotate | input | 1 | 1 = start after last winner, 0 = start at cfgStart |
| pollVal | output | IDW | Current poll count presented to all devices |
| pollValid | output | 1 | High while the poll count is being scanned |
| busy | output | 1 | Bus is owned |
| grantVec | output | NUM_DEV | One-hot owner indication |
| ownerId | output | IDW | ID of the current or most recent owner |

## Verification
The scan is tried with several request masks and start points. These include a requester exactly at the start point, one a few IDs past it, and one reached only after the count wraps past NUM_DEV-1. Together they separate correct start loading from correct stepping and wrapping, and the number of cycles to the grant is checked against the expected distance. Rotating-mode vectors with the same mask given twice in a row must give different winners, which only the last-winner start can produce. A request withdrawn during polling exercises the empty sweep. Requests from other devices raised while the bus is owned show that the grant and the counter stay frozen. Finally, a run in which all devices keep re-requesting shows strict consecutive round-robin order.

// File: rtl/pollArbPkg.sv
package pollArbPkg;
  typedef struct packed {
    logic loadStart;
    logic advance;
    logic capture;
    logic drop;
  } arbStrobeT;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_POLL = 2'd1,
    ST_OWN  = 2'd2
  } arbStateT;
endpackage

// File: rtl/pollArbDatapath.sv
module pollArbDatapath
  import pollArbPkg::*;
#(
  parameter int NUM_DEV = 8,
  parameter int IDW = $clog2(NUM_DEV)
) (
  input  logic               clk,
  input  logic               rstN,
  input  arbStrobeT          strb,
  input  logic [NUM_DEV-1:0] reqVec,
  input  logic [IDW-1:0]     cfgStart,
  input  logic               cfgRotate,
  output logic [IDW-1:0]     pollCnt,
  output logic               hit,
  output logic               ownerReq,
  output logic [NUM_DEV-1:0] grantVec,
  output logic [IDW-1:0]     ownerId
);
  localparam logic [IDW-1:0] LAST_ID = IDW'(NUM_DEV - 1);

  logic [IDW-1:0]     lastWin;
  logic [NUM_DEV-1:0] matchVec;

  function automatic logic [IDW-1:0] nextId(input logic [IDW-1:0] cur);
    return (cur == LAST_ID) ? '0 : cur + IDW'(1);
  endfunction

  // one comparator per device: requesting and addressed by the poll count
  for (genvar g = 0; g < NUM_DEV; g++) begin : gCmp
    assign matchVec[g] = reqVec[g] && (pollCnt == IDW'(g));
  end

  assign hit      = |matchVec;
  assign ownerReq = |(reqVec & grantVec);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pollCnt  <= '0;
      lastWin  <= LAST_ID;
      grantVec <= '0;
      ownerId  <= '0;
    end else begin
      if (strb.loadStart) begin
        pollCnt <= cfgRotate ? nextId(lastWin) : cfgStart;
      end else if (strb.advance) begin
        pollCnt <= nextId(pollCnt);
      end

      if (strb.capture) begin
        grantVec <= matchVec;
        ownerId  <= pollCnt;
        lastWin  <= pollCnt;
      end else if (strb.drop) begin
        grantVec <= '0;
      end
    end
  end
endmodule

// File: rtl/pollArbCtrl.sv
module pollArbCtrl
  import pollArbPkg::*;
#(
  parameter int NUM_DEV = 8,
  parameter int IDW = $clog2(NUM_DEV)
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      anyReq,
  input  logic      hit,
  input  logic      ownerReq,
  output arbStrobeT strb,
  output logic      busy,
  output logic      pollValid
);
  localparam logic [IDW-1:0] SWEEP_END = IDW'(NUM_DEV - 1);

  arbStateT       state, stateNxt;
  logic [IDW-1:0] sweepCnt;

  always_comb begin
    stateNxt = state;
    strb     = '0;
    unique case (state)
      ST_IDLE: begin
        if (anyReq) begin
          strb.loadStart = 1'b1;
          stateNxt       = ST_POLL;
        end
      end
      ST_POLL: begin
        if (hit) begin
          strb.capture = 1'b1;
          stateNxt     = ST_OWN;
        end else if (sweepCnt == SWEEP_END) begin
          stateNxt = ST_IDLE;
        end else begin
          strb.advance = 1'b1;
        end
      end
      ST_OWN: begin
        if (!ownerReq) begin
          strb.drop = 1'b1;
          stateNxt  = ST_IDLE;
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      sweepCnt <= '0;
    end else begin
      state <= stateNxt;
      if (strb.loadStart)    sweepCnt <= '0;
      else if (strb.advance) sweepCnt <= sweepCnt + IDW'(1);
    end
  end

  assign busy      = (state == ST_OWN);
  assign pollValid = (state == ST_POLL);
endmodule

// File: rtl/pollArbiter.sv
module pollArbiter
  import pollArbPkg::*;
#(
  parameter int NUM_DEV = 8,
  parameter int IDW = $clog2(NUM_DEV)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_DEV-1:0] reqVec,
  input  logic [IDW-1:0]     cfgStart,
  input  logic               cfgRotate,
  output logic [IDW-1:0]     pollVal,
  output logic               pollValid,
  output logic               busy,
  output logic [NUM_DEV-1:0] grantVec,
  output logic [IDW-1:0]     ownerId
);
  arbStrobeT strb;
  logic      hit;
  logic      ownerReq;

  pollArbCtrl #(.NUM_DEV(NUM_DEV), .IDW(IDW)) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .anyReq    (|reqVec),
    .hit       (hit),
    .ownerReq  (ownerReq),
    .strb      (strb),
    .busy      (busy),
    .pollValid (pollValid)
  );

  pollArbDatapath #(.NUM_DEV(NUM_DEV), .IDW(IDW)) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .reqVec    (reqVec),
    .cfgStart  (cfgStart),
    .cfgRotate (cfgRotate),
    .pollCnt   (pollVal),
    .hit       (hit),
    .ownerReq  (ownerReq),
    .grantVec  (grantVec),
    .ownerId   (ownerId)
  );
endmodule

// File: rtl/pollArbChecker.sv
module pollArbChecker #(
  parameter int NUM_DEV = 8,
  parameter int IDW = $clog2(NUM_DEV)
) (
  input logic               clk,
  input logic               rstN,
  input logic [NUM_DEV-1:0] reqVec,
  input logic [IDW-1:0]     pollVal,
  input logic               pollValid,
  input logic               busy,
  input logic [NUM_DEV-1:0] grantVec
);
  localparam logic [IDW-1:0] TOP_ID = IDW'(NUM_DEV - 1);

  AST_ONE_OWNER: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(grantVec)); // R5
  AST_GRANT_MATCHES_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (grantVec != '0) == busy); // R5
  AST_NO_POLL_WHEN_OWNED: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !pollValid); // R6
  AST_POLL_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> (!busy || $stable(pollVal))); // R6
  AST_POLL_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (pollValid && $past(pollValid)) |->
      pollVal == (($past(pollVal) == TOP_ID) ? '0 : $past(pollVal) + IDW'(1))); // R3
  AST_GRANT_TO_REQUESTER: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> (($past(reqVec) & grantVec) != '0)); // R4
  AST_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    (busy && ((reqVec & grantVec) == '0)) |=> !busy); // R7
  AST_POLL_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pollValid) |-> ($past(reqVec) != '0)); // R2
endmodule

bind pollArbiter pollArbChecker #(.NUM_DEV(NUM_DEV), .IDW(IDW)) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .reqVec    (reqVec),
  .pollVal   (pollVal),
  .pollValid (pollValid),
  .busy      (busy),
  .grantVec  (grantVec)
);

// File: tb/tb_pollArbiter.sv
module tb_pollArbiter;
  localparam int N = 8;
  localparam int W = 3;
  localparam int NV = 10;

  // vector table: mode, fixed start, request mask, expected winner, polls before hit
  localparam int V_ROT  [NV] = '{0, 0, 0, 0, 1, 1, 1, 1, 1, 1};
  localparam int V_START[NV] = '{0, 4, 6, 7, 0, 0, 0, 0, 0, 0};
  localparam int V_MASK [NV] = '{8'h14, 8'h14, 8'h06, 8'h80, 8'h81,
                                 8'h81, 8'h81, 8'h24, 8'h24, 8'hFF};
  localparam int V_WIN  [NV] = '{2, 4, 1, 7, 0, 7, 0, 2, 5, 6};
  localparam int V_DIST [NV] = '{2, 0, 3, 0, 0, 6, 0, 1, 2, 0};

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [N-1:0] reqVec = '0;
  logic [W-1:0] cfgStart = '0;
  logic         cfgRotate = 1'b0;
  logic [W-1:0] pollVal;
  logic         pollValid;
  logic         busy;
  logic [N-1:0] grantVec;
  logic [W-1:0] ownerId;

  int nTotal = 0;
  int nPass = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  pollArbiter #(.NUM_DEV(N), .IDW(W)) dut (
    .clk(clk), .rstN(rstN), .reqVec(reqVec), .cfgStart(cfgStart),
    .cfgRotate(cfgRotate), .pollVal(pollVal), .pollValid(pollValid),
    .busy(busy), .grantVec(grantVec), .ownerId(ownerId)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nTotal++;
    if (ok) nPass++;
    else $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
  endtask

  task automatic finish();
    finished = 1'b1;
    $display("%0d/%0d checks passed", nPass, nTotal);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      chk(1'b0, "watchdog", 0, 1);
      finish();
    end
  end

  initial begin
    int seen;
    int expOwn;
    int pv;
    int wt;

    repeat (3) @(negedge clk);
    chk(busy == 0 && grantVec == 0 && pollValid == 0, "R1 in reset", int'(busy), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk(busy == 0 && grantVec == 0 && pollValid == 0, "R1 after reset", int'(pollValid), 0);
    chk(pollValid == 0, "R2 no request no polling", int'(pollValid), 0);

    // table walk
    for (int v = 0; v < NV; v++) begin
      int s;
      s = (V_WIN[v] - V_DIST[v] + N) % N;
      reqVec = N'(V_MASK[v]);
      cfgStart = W'(V_START[v]);
      cfgRotate = V_ROT[v][0];
      for (int k = 0; k <= V_DIST[v]; k++) begin
        @(negedge clk);
        if (k == 0) begin
          chk(pollValid == 1, "R2 poll starts", int'(pollValid), 1);
          if (V_ROT[v] == 0) chk(pollVal == W'(s), "R8 fixed start", int'(pollVal), s);
          else chk(pollVal == W'(s), "R9 rotating start", int'(pollVal), s);
        end else begin
          chk(pollValid == 1 && busy == 0 && pollVal == W'((s + k) % N),
              "R3 poll step", int'(pollVal), (s + k) % N);
        end
      end
      @(negedge clk);
      chk(busy == 1 && ownerId == W'(V_WIN[v]), "R4 owner id", int'(ownerId), V_WIN[v]);
      chk(grantVec == N'(1 << V_WIN[v]), "R4 grant vector", int'(grantVec), 1 << V_WIN[v]);
      reqVec = '0;
      @(negedge clk);
      chk(busy == 0 && grantVec == 0, "R7 release", int'(busy), 0);
      @(negedge clk);
      chk(pollValid == 0, "R2 stays idle", int'(pollValid), 0);
    end

    // R6: others request while owned
    cfgRotate = 1'b0;
    cfgStart = '0;
    reqVec = 8'h08;
    repeat (5) @(negedge clk);
    chk(busy == 1 && grantVec == 8'h08, "R4 dev3 owns", int'(grantVec), 8);
    reqVec = 8'hFF;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk(busy == 1 && grantVec == 8'h08 && pollValid == 0 && pollVal == 3'd3,
          "R6 frozen while owned", int'(grantVec), 8);
    end
    reqVec = '0;
    @(negedge clk);
    chk(busy == 0 && grantVec == 0, "R7 release after contention", int'(busy), 0);
    @(negedge clk);

    // R10: request withdrawn, empty sweep
    reqVec = 8'h20;
    @(negedge clk);
    reqVec = '0;
    pv = 0;
    seen = 0;
    for (int k = 0; k < 12; k++) begin
      if (pollValid) pv++;
      if (busy) seen++;
      @(negedge clk);
    end
    chk(pv == N, "R10 sweep length", pv, N);
    chk(seen == 0 && pollValid == 0, "R10 returns idle", seen, 0);

    // R11: all devices keep re-requesting, rotating mode; last winner was 3
    cfgRotate = 1'b1;
    reqVec = 8'hFF;
    expOwn = 4;
    seen = 0;
    for (int gIdx = 0; gIdx < 2 * N; gIdx++) begin
      wt = 0;
      while (!busy && wt < 20) begin
        @(negedge clk);
        wt++;
      end
      chk(busy == 1 && ownerId == W'(expOwn), "R11 round-robin order", int'(ownerId), expOwn);
      chk($countones(grantVec) == 1, "R5 single owner", $countones(grantVec), 1);
      seen = seen | (1 << ownerId);
      repeat (2) @(negedge clk);
      reqVec[ownerId] = 1'b0;
      @(negedge clk);
      reqVec = 8'hFF;
      expOwn = (expOwn + 1) % N;
    end
    chk(seen == 8'hFF, "R11 every device granted", seen, 8'hFF);
    reqVec = '0;
    repeat (3) @(negedge clk);
    finish();
  end
endmodule